// File: doc/BRIEF.md
# Selectable Gate Window Controller

This block produces the measurement window for a reciprocal (equal-precision) frequency counter. It runs on a reference clock and counts whole reference cycles to time each window, so the window length is exact to the cycle. Downstream logic synchronises the window to the measured signal, counts both clocks, and latches the counts when the window closes. This block only decides when the window is open.

Three debounced button levels drive it. The first steps the window length through three settings, each ten times the previous one. The second requests a single measurement. The third switches between single-shot operation and free-running operation. In free-running mode, windows repeat on their own. Every window is followed by a fixed hold-off, so the downstream latch has time to settle before the next window opens. The selected setting is presented as a two-bit code for a display, and a one-cycle completion strobe marks the end of each window.

Top module: `gate_window_ctrl`

## Requirements
- R1: While reset is high and after it is released, the outputs are as follows until a button is pressed: `gate_open` is low, `meas_done` is low, `range_code` is 0, and the block is in single-shot mode.
- R2: Each rising edge on `range_btn` advances `range_code` through 0, 1, 2 and back to 0. The code never takes the value 3. Code 0 selects the short window, code 1 the medium window, and code 2 the long window.
- R3: `gate_open` stays high for exactly `BASE_CYCLES`, 10×`BASE_CYCLES` or 100×`BASE_CYCLES` reference cycles for codes 0, 1 and 2. With the defaults these are 5,000,000, 50,000,000 and 500,000,000 cycles.
- R4: In single-shot mode, each rising edge on `measure_btn` opens exactly one window. After that window the block remains idle with `gate_open` low.
- R5: `meas_done` is high for exactly one cycle, in the cycle after `gate_open` falls. It pulses once per window and at no other time.
- R6: A rising edge on `measure_btn` has no effect while a window is open or during the hold-off after it: no extra window is opened and the current window keeps its length.
- R7: A `range_btn` press during an open window updates `range_code` at once but does not change the length of that window. The next window uses the new length.
- R8: Each rising edge on `auto_btn` toggles free-running mode. In free-running mode, windows open repeatedly without presses, and `gate_open` stays low for at least `HOLDOFF` cycles between windows.
- R9: When free-running mode is switched off, any window already in progress completes normally, and no further window opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| range_btn | input | 1 | Debounced level; rising edge steps the window length |
| measure_btn | input | 1 | Debounced level; rising edge requests one window |
| auto_btn | input | 1 | Debounced level; rising edge toggles free-running mode |
| gate_open | output | 1 | Registered window level |
| range_code | output | 2 | Selected window setting (0 short, 1 medium, 2 long) |
| meas_done | output | 1 | One-cycle strobe in the cycle after the window closes |

## Verification
The hardest case to reach is a range change that lands while a window is already open. The stimulus starts a medium window and presses the range button well inside it. It then measures the width of that window and of the next window, which must differ. Press rejection during the hold-off is also difficult, because the press must land in the short gap after the completion strobe. The bench waits for the window's falling edge and presses immediately, so the press is detected inside the hold-off.

// File: rtl/gwc_pkg.sv
package gwc_pkg;

  typedef enum logic [1:0] {
    RNG_SHORT = 2'd0,
    RNG_MID   = 2'd1,
    RNG_LONG  = 2'd2
  } gate_range_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_HOLD = 2'd2
  } win_state_e;

  function automatic gate_range_e range_next(input gate_range_e cur);
    case (cur)
      RNG_SHORT: range_next = RNG_MID;
      RNG_MID:   range_next = RNG_LONG;
      default:   range_next = RNG_SHORT;
    endcase
  endfunction

endpackage

// File: rtl/gwc_press_detect.sv
module gwc_press_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level,
  output logic [N-1:0] press
);
  logic [N-1:0] level_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        level_d[i] <= 1'b0;
        press[i]   <= 1'b0;
      end else begin
        level_d[i] <= level[i];
        press[i]   <= level[i] & ~level_d[i];
      end
    end
  end
endmodule

// File: rtl/gwc_range_sel.sv
module gwc_range_sel
  import gwc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output gate_range_e range_q
);
  always_ff @(posedge clk) begin
    if (rst)       range_q <= RNG_SHORT;
    else if (step) range_q <= range_next(range_q);
  end
endmodule

// File: rtl/gwc_window_timer.sv
module gwc_window_timer
  import gwc_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 5_000_000,
  parameter int unsigned HOLDOFF     = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        auto_en,
  input  logic        trig,
  input  gate_range_e range_sel,
  output logic        gate_open,
  output logic        meas_done
);
  localparam int unsigned LEN_LONG_I = BASE_CYCLES * 100;
  localparam int CW = $clog2(LEN_LONG_I + 1);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [CW-1:0] LEN_S = CW'(BASE_CYCLES);
  localparam logic [CW-1:0] LEN_M = CW'(BASE_CYCLES * 10);
  localparam logic [CW-1:0] LEN_L = CW'(LEN_LONG_I);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLDOFF - 1);

  win_state_e    state_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] hcnt_q;
  logic [CW-1:0] len_pick;

  always_comb begin
    case (range_sel)
      RNG_MID:  len_pick = LEN_M;
      RNG_LONG: len_pick = LEN_L;
      default:  len_pick = LEN_S;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      len_q     <= LEN_S;
      cnt_q     <= '0;
      hcnt_q    <= '0;
      gate_open <= 1'b0;
      meas_done <= 1'b0;
    end else begin
      meas_done <= (state_q == ST_HOLD) && (hcnt_q == '0);
      case (state_q)
        ST_IDLE: begin
          if (auto_en || trig) begin
            state_q   <= ST_OPEN;
            len_q     <= len_pick;
            cnt_q     <= '0;
            gate_open <= 1'b1;
          end
        end
        ST_OPEN: begin
          if (cnt_q == len_q - 1'b1) begin
            state_q   <= ST_HOLD;
            hcnt_q    <= '0;
            gate_open <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (hcnt_q == HOLD_LAST) state_q <= ST_IDLE;
          else                     hcnt_q  <= hcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gate_window_ctrl.sv
module gate_window_ctrl
  import gwc_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 5_000_000,
  parameter int unsigned HOLDOFF     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       range_btn,
  input  logic       measure_btn,
  input  logic       auto_btn,
  output logic       gate_open,
  output logic [1:0] range_code,
  output logic       meas_done
);
  localparam int NBTN = 3;
  localparam int B_RANGE = 0;
  localparam int B_MEAS  = 1;
  localparam int B_AUTO  = 2;

  logic [NBTN-1:0] press;
  gate_range_e     range_q;
  logic            auto_q;

  gwc_press_detect #(.N(NBTN)) press_i (
    .clk   (clk),
    .rst   (rst),
    .level ({auto_btn, measure_btn, range_btn}),
    .press (press)
  );

  gwc_range_sel range_i (
    .clk     (clk),
    .rst     (rst),
    .step    (press[B_RANGE]),
    .range_q (range_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                 auto_q <= 1'b0;
    else if (press[B_AUTO])  auto_q <= ~auto_q;
  end

  gwc_window_timer #(
    .BASE_CYCLES (BASE_CYCLES),
    .HOLDOFF     (HOLDOFF)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .auto_en   (auto_q),
    .trig      (press[B_MEAS]),
    .range_sel (range_q),
    .gate_open (gate_open),
    .meas_done (meas_done)
  );

  assign range_code = range_q;
endmodule

// File: rtl/gwc_checker.sv
module gwc_checker #(
  parameter int unsigned BASE_CYCLES = 5_000_000,
  parameter int unsigned HOLDOFF     = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       gate_open,
  input logic       meas_done,
  input logic [1:0] range_code
);
  logic [31:0] hi_cnt;
  logic [31:0] lo_cnt;
  logic [1:0]  cap_range;
  logic        seen_fall;

  function automatic logic [31:0] exp_len(input logic [1:0] c);
    case (c)
      2'd1:    exp_len = 32'(BASE_CYCLES * 10);
      2'd2:    exp_len = 32'(BASE_CYCLES * 100);
      default: exp_len = 32'(BASE_CYCLES);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      cap_range <= '0;
      seen_fall <= 1'b0;
    end else begin
      hi_cnt <= gate_open ? hi_cnt + 1 : '0;
      if (!gate_open) begin
        if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1;
        cap_range <= range_code;
      end else begin
        lo_cnt <= '0;
      end
      if (hi_cnt != 0 && !gate_open) seen_fall <= 1'b1;
    end
  end

  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    range_code != 2'd3); // R2
  AST_RANGE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(range_code) |->
      range_code == (($past(range_code) == 2'd2) ? 2'd0 : $past(range_code) + 2'd1)); // R2
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_open) |-> hi_cnt == exp_len(cap_range)); // R3
  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_open) |=> meas_done); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    meas_done |=> !meas_done); // R5
  AST_DONE_ONLY_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    meas_done |-> (!gate_open && $past(gate_open, 2))); // R5
  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_open) && seen_fall) |-> lo_cnt >= HOLDOFF); // R8
endmodule

bind gate_window_ctrl gwc_checker #(
  .BASE_CYCLES (BASE_CYCLES),
  .HOLDOFF     (HOLDOFF)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .gate_open  (gate_open),
  .meas_done  (meas_done),
  .range_code (range_code)
);

// File: tb/gate_window_ctrl_tb_top.sv
`timescale 1ns/1ps
module gate_window_ctrl_tb_top;
  localparam int unsigned BASE = 20;
  localparam int unsigned HOLD = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       range_btn = 1'b0;
  logic       measure_btn = 1'b0;
  logic       auto_btn = 1'b0;
  logic       gate_open;
  logic [1:0] range_code;
  logic       meas_done;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  int prev_g = 0, hi_run = 0, lo_run = 0, last_len = 0;
  int wins_open = 0, wins_done = 0, done_cnt = 0, done_err = 0;
  int pend = 0, min_gap = 0;

  always #4 clk = ~clk;

  gate_window_ctrl #(.BASE_CYCLES(BASE), .HOLDOFF(HOLD)) dut_i (
    .clk(clk), .rst(rst), .range_btn(range_btn), .measure_btn(measure_btn),
    .auto_btn(auto_btn), .gate_open(gate_open), .range_code(range_code),
    .meas_done(meas_done)
  );

  always @(negedge clk) begin
    if (rst) begin
      prev_g = 0; hi_run = 0; lo_run = 0; pend = 0;
    end else begin
      if (int'(meas_done) != pend) done_err++;
      if (meas_done) done_cnt++;
      pend = 0;
      if (gate_open && prev_g == 0) begin
        wins_open++;
        if (lo_run < min_gap) min_gap = lo_run;
        hi_run = 1;
      end else if (gate_open) begin
        hi_run++;
      end else if (prev_g == 1) begin
        last_len = hi_run;
        wins_done++;
        pend = 1;
      end
      if (gate_open) lo_run = 0; else lo_run++;
      prev_g = int'(gate_open);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int which);
    @(negedge clk);
    case (which)
      0: range_btn = 1'b1;
      1: measure_btn = 1'b1;
      default: auto_btn = 1'b1;
    endcase
    wait_cyc(2);
    range_btn = 1'b0; measure_btn = 1'b0; auto_btn = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done(input int target, input string tag);
    int guard = 0;
    while (wins_done < target && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " window completed"}, int'(wins_done >= target), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 gate in reset", int'(gate_open), 0);
    chk("R1 done in reset", int'(meas_done), 0);
    rst = 1'b0;
    wait_cyc(30);
    chk("R1 gate after reset", int'(gate_open), 0);
    chk("R1 range after reset", int'(range_code), 0);
    chk("R1 no window (manual mode)", wins_open, 0);
  endtask

  task automatic t_range_cycle();
    press(0); wait_cyc(2); chk("R2 step to 1", int'(range_code), 1);
    press(0); wait_cyc(2); chk("R2 step to 2", int'(range_code), 2);
    press(0); wait_cyc(2); chk("R2 wrap to 0", int'(range_code), 0);
  endtask

  task automatic t_manual(input int len);
    int o0 = wins_open;
    int d0 = wins_done;
    press(1);
    wait_done(d0 + 1, "R4");
    chk("R3 window length", last_len, len);
    wait_cyc(3 * len + 40);
    chk("R4 single window only", wins_open - o0, 1);
    chk("R4 idle after window", int'(gate_open), 0);
  endtask

  task automatic t_ignore();
    int o0 = wins_open;
    int d0 = wins_done;
    press(1);
    wait_cyc(4);
    press(1);
    wait_done(d0 + 1, "R6");
    chk("R6 length unchanged", last_len, BASE);
    press(1);
    wait_cyc(80);
    chk("R6 presses in window/hold-off ignored", wins_open - o0, 1);
  endtask

  task automatic t_range_mid();
    int d0;
    press(0); wait_cyc(2);
    d0 = wins_done;
    press(1);
    wait_cyc(30);
    press(0); wait_cyc(2);
    chk("R7 code updates mid-window", int'(range_code), 2);
    chk("R7 window still open", int'(gate_open), 1);
    wait_done(d0 + 1, "R7");
    chk("R7 old length kept", last_len, BASE * 10);
    wait_cyc(30);
    press(1);
    wait_done(d0 + 2, "R7");
    chk("R7 next window uses new length", last_len, BASE * 100);
    wait_cyc(30);
    press(0); wait_cyc(2);
    chk("R2 back to 0", int'(range_code), 0);
  endtask

  task automatic t_auto();
    int d0 = wins_done;
    int o1;
    min_gap = 1000000;
    press(2);
    wait_done(d0 + 4, "R8");
    chk("R8 auto window length", last_len, BASE);
    chk("R8 hold-off gap", int'(min_gap >= int'(HOLD)), 1);
    chk("R8 repeated windows", int'(wins_open - d0 >= 4), 1);
    press(2);
    wait_cyc(60);
    o1 = wins_open;
    chk("R9 last window completed", wins_done, wins_open);
    wait_cyc(200);
    chk("R9 no window after auto off", wins_open, o1);
    chk("R9 gate low", int'(gate_open), 0);
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    t_range_cycle();
    t_manual(BASE);
    press(0); wait_cyc(2);
    t_manual(BASE * 10);
    press(0); wait_cyc(2);
    t_manual(BASE * 100);
    press(0); wait_cyc(2);
    chk("R2 wrap after long", int'(range_code), 0);
    t_ignore();
    t_range_mid();
    t_auto();
    chk("R5 done pulses match windows", done_cnt, wins_done);
    chk("R5 done timing errors", done_err, 0);
    summary();
  end
endmodule